// File: doc/BRIEF.md
# Device Identity Field Extractor

This block fetches a device's 256-word identity block over a byte-wide task-file register port and returns one chosen field from it. A caller picks one of four fields (serial number, firmware revision, model string or sector capacity) and pulses a start strobe. The block waits for the device to report ready, issues the identify command and waits for the data request. It then reads the whole 512-byte block, because the device only leaves its data phase once every byte has been taken. Only the bytes of the chosen field are passed on as a byte stream.

Text fields are stored in the block with the two characters of each word in reversed order, so the block swaps them: within each kept word it emits the second byte read before the first. The capacity field is a number, not text. Its bytes are emitted in the order they are read and then padded with zero bytes up to a configurable result width. After the data phase the block reads the alternate status register and then the status register, and reports completion with a result code. It does not interpret the strings.

A field code it does not recognise is rejected at once, without any bus traffic. A device error bit or a wait that runs past the timeout ends the operation with a device-failure result.

Top module: `idf_extractor`

## Requirements
- R1: On a start with a valid field, the block reads status (address 7) until bit 7 (busy) is 0 and bit 6 (ready) is 1. Only then does it write 0xEC to address 7. This is the only register write it ever makes.
- R2: After the command write, the block reads status again until bit 7 is 0 and bit 3 (data request) is 1. It reads no data before that.
- R3: For every accepted field, the block reads exactly 2*BLOCK_WORDS bytes from the data register (address 0). Byte 2w is the even byte of word w, and byte 2w+1 is its odd byte.
- R4: Field codes select these windows of words: 0 serial number (words 10 to 19), 1 firmware revision (words 23 to 26), 2 model string (words 27 to 46), 3 capacity (words 60 and 61).
- R5: For fields 0, 1 and 2, the out_byte stream carries each kept word as its odd byte followed by its even byte. Words are taken in ascending order, and out_valid marks each byte.
- R6: For field 3, the stream carries the four capacity bytes in read order. These are followed by SECT_BYTES-4 zero bytes.
- R7: After the data bytes, the block reads address 14 (alternate status) and then address 7 (status). It then pulses done for one cycle with result 0 (success).
- R8: A start with field code 4 to 7 makes done pulse in the next cycle with result 1 (bad selection). There is no register access and no output byte.
- R9: If a status read during either wait has bit 0 (error) set, done pulses with result 2 (device failure). No further register access follows.
- R10: If a wait is not satisfied within TIMEOUT_CYCLES cycles, the next status read ends the operation with result 2.
- R11: reg_rd and reg_wr are never high together. A request holds its address until reg_ack. busy is low whenever done is high, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| field_sel | input | 3 | Field code (0 to 3 valid) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 bad selection, 2 device failure |
| reg_rd | output | 1 | Register read request, held until ack |
| reg_wr | output | 1 | Register write request, held until ack |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | One-cycle acknowledge from the register engine |
| reg_rdata | input | 8 | Read data, valid with reg_ack |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Extracted field byte |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 60 and keeps the full 256-word block and an 8-byte capacity result. With the short timeout, a device stuck busy reaches the timeout outcome in a few dozen cycles. The full block size means every run sweeps all 512 data reads, with the windows at their true offsets, and adds four zero pad bytes after the capacity words. The device model returns ready before data request, so it can tell whether each wait looks at the right status bit.

// File: rtl/idf_pkg.sv
package idf_pkg;
    localparam logic [3:0] ADDR_DATA    = 4'h0;
    localparam logic [3:0] ADDR_STATUS  = 4'h7;
    localparam logic [3:0] ADDR_ALTSTAT = 4'hE;
    localparam logic [7:0] CMD_IDENTIFY = 8'hEC;

    localparam int BIT_BSY  = 7;
    localparam int BIT_DRDY = 6;
    localparam int BIT_DRQ  = 3;
    localparam int BIT_ERR  = 0;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_BADSEL  = 2'd1,
        RES_DEVFAIL = 2'd2
    } result_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WAIT_RDY,
        PH_SEND_CMD,
        PH_WAIT_DRQ,
        PH_XFER,
        PH_EMIT_EVEN,
        PH_ZFILL,
        PH_TAIL_ALT,
        PH_TAIL_STAT
    } phase_e;
endpackage

// File: rtl/idf_window.sv
module idf_window #(
    parameter int WW = 8
) (
    input  logic [2:0]    field,
    output logic          valid,
    output logic [WW-1:0] off,
    output logic [WW-1:0] len,
    output logic          swap
);
    always_comb begin
        valid = 1'b1;
        swap  = 1'b1;
        off   = '0;
        len   = '0;
        case (field)
            3'd0: begin off = WW'(10); len = WW'(10); end
            3'd1: begin off = WW'(23); len = WW'(4);  end
            3'd2: begin off = WW'(27); len = WW'(20); end
            3'd3: begin off = WW'(60); len = WW'(2); swap = 1'b0; end
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/idf_timeout.sv
module idf_timeout #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/idf_extractor.sv
module idf_extractor
    import idf_pkg::*;
#(
    parameter int BLOCK_WORDS    = 256,
    parameter int TIMEOUT_CYCLES = 100_000_000,
    parameter int SECT_BYTES     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] field_sel,
    output logic       busy,
    output logic       done,
    output logic [1:0] result,
    output logic       reg_rd,
    output logic       reg_wr,
    output logic [3:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic       reg_ack,
    input  logic [7:0] reg_rdata,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    localparam int IW          = $clog2(2 * BLOCK_WORDS);
    localparam int WW          = IW - 1;
    localparam int ZFILL_BYTES = SECT_BYTES - 4;

    typedef struct packed {
        phase_e        phase;
        logic [2:0]    field;
        logic          rd;
        logic          wr;
        logic [3:0]    addr;
        logic [7:0]    wdata;
        logic [IW-1:0] idx;
        logic [7:0]    hold;
        logic          out_valid;
        logic [7:0]    out_byte;
        logic          done;
        result_e       result;
    } state_t;

    state_t q, d;

    logic [2:0]    win_field;
    logic          win_valid;
    logic [WW-1:0] win_off;
    logic [WW-1:0] win_len;
    logic          win_swap;
    logic          tmo_run;
    logic          tmo_hit;

    assign win_field = (q.phase == PH_IDLE) ? field_sel : q.field;

    idf_window #(.WW(WW)) u_window (
        .field (win_field),
        .valid (win_valid),
        .off   (win_off),
        .len   (win_len),
        .swap  (win_swap)
    );

    assign tmo_run = (q.phase == PH_WAIT_RDY) || (q.phase == PH_WAIT_DRQ);

    idf_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_hit)
    );

    logic [WW-1:0] word;
    logic          odd;
    logic [IW-1:0] idx_nx;
    logic          in_win;
    logic          st_fail;
    logic          st_rdy;
    logic          st_drq;
    phase_e        after_block;

    always_comb begin
        word    = q.idx[IW-1:1];
        odd     = q.idx[0];
        idx_nx  = q.idx + 1'b1;
        in_win  = ({1'b0, word} >= {1'b0, win_off}) &&
                  ({1'b0, word} <  ({1'b0, win_off} + {1'b0, win_len}));
        st_fail = tmo_hit || reg_rdata[BIT_ERR];
        st_rdy  = !reg_rdata[BIT_BSY] && reg_rdata[BIT_DRDY];
        st_drq  = !reg_rdata[BIT_BSY] && reg_rdata[BIT_DRQ];
        after_block = (ZFILL_BYTES > 0 && !win_swap) ? PH_ZFILL : PH_TAIL_ALT;

        d           = q;
        d.out_valid = 1'b0;
        d.done      = 1'b0;

        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (win_valid) begin
                        d.field = field_sel;
                        d.idx   = '0;
                        d.phase = PH_WAIT_RDY;
                    end else begin
                        d.done   = 1'b1;
                        d.result = RES_BADSEL;
                    end
                end
            end
            PH_WAIT_RDY, PH_WAIT_DRQ: begin
                if (!q.rd) begin
                    d.rd   = 1'b1;
                    d.addr = ADDR_STATUS;
                end else if (reg_ack) begin
                    d.rd = 1'b0;
                    if (st_fail) begin
                        d.phase  = PH_IDLE;
                        d.done   = 1'b1;
                        d.result = RES_DEVFAIL;
                    end else if (q.phase == PH_WAIT_RDY && st_rdy) begin
                        d.phase = PH_SEND_CMD;
                    end else if (q.phase == PH_WAIT_DRQ && st_drq) begin
                        d.phase = PH_XFER;
                    end
                end
            end
            PH_SEND_CMD: begin
                if (!q.wr) begin
                    d.wr    = 1'b1;
                    d.addr  = ADDR_STATUS;
                    d.wdata = CMD_IDENTIFY;
                end else if (reg_ack) begin
                    d.wr    = 1'b0;
                    d.phase = PH_WAIT_DRQ;
                end
            end
            PH_XFER: begin
                if (!q.rd) begin
                    d.rd   = 1'b1;
                    d.addr = ADDR_DATA;
                end else if (reg_ack) begin
                    d.rd  = 1'b0;
                    d.idx = idx_nx;
                    if (idx_nx == '0)
                        d.phase = after_block;
                    if (in_win) begin
                        if (!win_swap) begin
                            d.out_valid = 1'b1;
                            d.out_byte  = reg_rdata;
                        end else if (!odd) begin
                            d.hold = reg_rdata;
                        end else begin
                            d.out_valid = 1'b1;
                            d.out_byte  = reg_rdata;
                            d.phase     = PH_EMIT_EVEN;
                        end
                    end
                end
            end
            PH_EMIT_EVEN: begin
                d.out_valid = 1'b1;
                d.out_byte  = q.hold;
                d.phase     = (q.idx == '0) ? after_block : PH_XFER;
            end
            PH_ZFILL: begin
                d.out_valid = 1'b1;
                d.out_byte  = 8'h00;
                d.idx       = idx_nx;
                if (idx_nx == IW'(ZFILL_BYTES)) begin
                    d.idx   = '0;
                    d.phase = PH_TAIL_ALT;
                end
            end
            PH_TAIL_ALT: begin
                if (!q.rd) begin
                    d.rd   = 1'b1;
                    d.addr = ADDR_ALTSTAT;
                end else if (reg_ack) begin
                    d.rd    = 1'b0;
                    d.phase = PH_TAIL_STAT;
                end
            end
            PH_TAIL_STAT: begin
                if (!q.rd) begin
                    d.rd   = 1'b1;
                    d.addr = ADDR_STATUS;
                end else if (reg_ack) begin
                    d.rd     = 1'b0;
                    d.phase  = PH_IDLE;
                    d.done   = 1'b1;
                    d.result = RES_OK;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.phase != PH_IDLE);
    assign done      = q.done;
    assign result    = q.result;
    assign reg_rd    = q.rd;
    assign reg_wr    = q.wr;
    assign reg_addr  = q.addr;
    assign reg_wdata = q.wdata;
    assign out_valid = q.out_valid;
    assign out_byte  = q.out_byte;
endmodule

// File: rtl/idf_extractor_chk.sv
module idf_extractor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] field_sel,
    input logic       busy,
    input logic       done,
    input logic [1:0] result,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_ack,
    input logic       out_valid
);
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R11

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_ack) |=> (reg_rd && $stable(reg_addr))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_ONLY_IDENTIFY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr == 4'h7 && reg_wdata == 8'hEC)); // R1

    AST_BAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && field_sel > 3'd3) |=> (done && result == 2'd1 && !reg_rd && !reg_wr)); // R8

    AST_OUT_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R5
endmodule

bind idf_extractor idf_extractor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .field_sel (field_sel),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_ack   (reg_ack),
    .out_valid (out_valid)
);

// File: tb/tb_idf_extractor.sv
module tb_idf_extractor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] field_sel = 3'd0;
    logic       busy, done, reg_rd, reg_wr, out_valid;
    logic [1:0] result;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, out_byte;
    logic       reg_ack = 1'b0;
    logic [7:0] reg_rdata = 8'h00;

    always #5 clk = ~clk;

    idf_extractor #(.BLOCK_WORDS(256), .TIMEOUT_CYCLES(60), .SECT_BYTES(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .field_sel(field_sel),
        .busy(busy), .done(done), .result(result),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    int nchk = 0;
    int nerr = 0;

    // device model state
    int       stat_mode = 0;   // 0 normal, 1 stuck busy, 2 error
    int       busy_left = 0;
    bit       cmd_seen  = 0;
    logic [7:0] last_stat = 8'h00;
    int       n_data = 0;
    int       n_ops  = 0;
    int       viol_r1 = 0;
    int       viol_r2 = 0;
    logic [3:0] prev1 = 4'h0;
    logic [3:0] prev2 = 4'h0;
    int       n_out = 0;

    logic [7:0] expq[$];
    string      tagq[$];

    function automatic logic [7:0] even_b(int w);
        return 8'(w) ^ 8'hA5;
    endfunction
    function automatic logic [7:0] odd_b(int w);
        return 8'(w) + 8'h11;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register engine / device model
    always @(posedge clk) begin
        logic [7:0] sv;
        if (!rst_n) begin
            reg_ack <= 1'b0;
        end else begin
            reg_ack <= 1'b0;
            if ((reg_rd || reg_wr) && !reg_ack) begin
                reg_ack <= 1'b1;
                n_ops++;
                if (reg_wr) begin
                    if (reg_addr == 4'h7 && reg_wdata == 8'hEC) begin
                        if (last_stat[7] || !last_stat[6]) viol_r1++;
                        cmd_seen  = 1;
                        busy_left = 2;
                    end else begin
                        viol_r1++;
                    end
                end else if (reg_addr == 4'h0) begin
                    if (!cmd_seen || last_stat[7] || !last_stat[3]) viol_r2++;
                    reg_rdata <= n_data[0] ? odd_b(n_data >> 1) : even_b(n_data >> 1);
                    n_data++;
                    prev2 = prev1;
                    prev1 = reg_addr;
                end else begin
                    if (stat_mode == 1)      sv = 8'h80;
                    else if (stat_mode == 2) sv = 8'h41;
                    else if (busy_left > 0) begin busy_left--; sv = 8'h80; end
                    else                     sv = cmd_seen ? 8'h48 : 8'h40;
                    last_stat = sv;
                    reg_rdata <= sv;
                    prev2 = prev1;
                    prev1 = reg_addr;
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected byte", {24'h0, out_byte}, 32'h0);
            end else begin
                logic [7:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(out_byte == e, t, {24'h0, out_byte}, {24'h0, e});
            end
        end
    end

    task automatic push_field(logic [2:0] f);
        int off, len;
        case (f)
            3'd0: begin off = 10; len = 10; end
            3'd1: begin off = 23; len = 4;  end
            3'd2: begin off = 27; len = 20; end
            default: begin off = 60; len = 2; end
        endcase
        for (int w = off; w < off + len; w++) begin
            if (f == 3'd3) begin
                expq.push_back(even_b(w)); tagq.push_back("R6 capacity byte");
                expq.push_back(odd_b(w));  tagq.push_back("R6 capacity byte");
            end else begin
                expq.push_back(odd_b(w));  tagq.push_back("R5 swapped odd byte");
                expq.push_back(even_b(w)); tagq.push_back("R5 swapped even byte");
            end
        end
        if (f == 3'd3)
            for (int z = 0; z < 4; z++) begin
                expq.push_back(8'h00); tagq.push_back("R6 zero fill");
            end
    endtask

    task automatic run(input logic [2:0] f, input int mode, output logic [1:0] res, output bit got);
        stat_mode = mode; busy_left = 2; cmd_seen = 0; last_stat = 8'h00;
        n_data = 0; n_ops = 0; viol_r1 = 0; viol_r2 = 0; n_out = 0;
        prev1 = 4'h0; prev2 = 4'h0;
        if (mode == 0 && f < 3'd4) push_field(f);
        @(negedge clk);
        start = 1'b1; field_sel = f;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin got = 1; res = result; break; end
            @(negedge clk);
        end
        if (!got) res = 2'd3;
    endtask

    task automatic good_run(logic [2:0] f, int nbytes);
        logic [1:0] res; bit got;
        run(f, 0, res, got);
        chk(got, "R7 done seen", got, 1);
        chk(res == 2'd0, "R7 result ok", res, 0);
        chk(busy == 1'b0, "R11 busy low with done", busy, 0);
        chk(n_data == 512, "R3 data reads", n_data, 512);
        chk(prev2 == 4'hE && prev1 == 4'h7, "R7 tail order", {prev2, prev1}, 8'hE7);
        chk(viol_r1 == 0, "R1 command after ready", viol_r1, 0);
        chk(viol_r2 == 0, "R2 data after request", viol_r2, 0);
        chk(n_out == nbytes, "R4 window size", n_out, nbytes);
        chk(expq.size() == 0, "R5 all bytes emitted", expq.size(), 0);
        expq.delete(); tagq.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [1:0] res; bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !out_valid, "R11 reset state", {busy, done, out_valid}, 0);
        chk(!reg_rd && !reg_wr, "R11 reset bus idle", {reg_rd, reg_wr}, 0);

        good_run(3'd0, 20);   // serial number
        good_run(3'd1, 8);    // firmware revision
        good_run(3'd2, 40);   // model string
        good_run(3'd3, 8);    // capacity + zero fill

        run(3'd5, 0, res, got);
        chk(got && res == 2'd1, "R8 bad field result", res, 1);
        chk(n_ops == 0 && n_out == 0, "R8 no bus or output", n_ops + n_out, 0);
        run(3'd7, 0, res, got);
        chk(got && res == 2'd1, "R8 field 7 rejected", res, 1);

        run(3'd1, 2, res, got);
        chk(got && res == 2'd2, "R9 error bit result", res, 2);
        chk(!cmd_seen && n_data == 0, "R9 no command after error", n_ops, 1);
        repeat (5) @(negedge clk);
        chk(n_ops == 1, "R9 bus quiet after error", n_ops, 1);

        run(3'd2, 1, res, got);
        chk(got && res == 2'd2, "R10 timeout result", res, 2);
        chk(!cmd_seen && n_data == 0 && n_ops > 1, "R10 polled then gave up", n_ops, 2);

        good_run(3'd3, 8);    // recovery after failures

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule